// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a clocked system read and write an external asynchronous static RAM of 64K words by 16 bits. The RAM has separate lower and upper byte lanes. On the system side a request carries an address, a write flag, a two-bit byte mask and write data. Each request finishes with one response beat, which holds the read data for a read and zero for a write. On the memory side the block drives:
- the word address;
- active-low chip select, read (output) enable and write enable;
- one active-low enable per byte lane;
- the shared data bus, split into an output-enable, an outgoing data vector and an incoming data vector.

Every analog timing limit is a parameter in picoseconds, as is the clock period. Each limit becomes a whole number of clock cycles, rounded up and never below one. The cycles are spent in this order: setup, the read wait or write pulse, and then recovery. When the bus changes direction between two transfers, a quiet gap is inserted so that the controller and the memory never drive the bus at the same time.

The request port is valid/ready. A request moves when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is high only while the controller is idle and no response is waiting. The response port is valid/ready as well. `rsp_valid` stays high with `rsp_rdata` unchanged until `rsp_ready` is high at an edge. The client applies back-pressure only by holding `rsp_ready` low, and while it does so no new request is taken.

Top module: `sram_ctrl`

## Requirements
- R1: After reset the bus is quiet: `mem_cs_n`, `mem_rd_n` and `mem_wr_n` are high, `mem_be_n` is all ones, `mem_dq_oe` is low, `req_ready` is high and `rsp_valid` is low.
- R2: A request is taken only on an edge with `req_valid` and `req_ready` both high. `req_ready` is low from acceptance until the response has been consumed. `rsp_valid` and `rsp_rdata` hold steady while `rsp_ready` is low. A write's response data is zero.
- R3: For a read, address and chip select are held for at least ceil(15 ns / clock) cycles, and the read enable is low for at least ceil(7 ns / clock) cycles, before the data is captured. At the default 5 ns clock `rsp_valid` appears 3 cycles after the accepting edge when no turnaround is needed.
- R4: For a write, the write-enable low pulse lasts at least ceil(10 ns / clock) cycles. Address and data are both held for at least 2 cycles before write enable rises at the defaults. At the defaults `rsp_valid` appears 4 cycles after the accepting edge when no turnaround is needed.
- R5: Byte mask bit 0 selects the lower lane (data bits 7:0, `mem_be_n[0]`). Bit 1 selects the upper lane (bits 15:8, `mem_be_n[1]`). A selected lane's enable is driven low during the transfer, and an unselected lane's enable stays high.
- R6: For a read, each unselected lane of `rsp_rdata` is zero, whatever the memory presents on that lane.
- R7: During a write, `mem_dq_out` carries the write data only on selected lanes and zero on the others. A lane that is not selected keeps its stored contents.
- R8: `mem_dq_oe` is high only during write transfers and is never high while `mem_rd_n` is low.
- R9: When a read follows a write, `mem_dq_oe` has been low for at least ceil(7 ns / clock) cycles (2 at the defaults) before `mem_rd_n` falls. When a write follows a read, `mem_rd_n` has been high for at least 2 cycles before `mem_dq_oe` rises. Each direction change adds 2 cycles of latency at the defaults.
- R10: Whenever `mem_cs_n` is high, `mem_rd_n` and `mem_wr_n` are high and `mem_be_n` is all ones.
- R11: A request with byte mask 00 still runs a full transfer. As a write it changes no stored lane, and as a read it returns zero.
- R12: `mem_wr_n` is low only while `mem_cs_n` is low and `mem_rd_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_be | input | LANES | Byte mask, bit 0 lower lane |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Client takes the response |
| rsp_rdata | output | DATA_W | Read data, unselected lanes zero; zero for writes |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Memory output enable, active low |
| mem_wr_n | output | 1 | Write enable, active low |
| mem_be_n | output | LANES | Byte lane enables, active low |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_out | output | DATA_W | Data driven to the bus |
| mem_dq_in | input | DATA_W | Data sampled from the bus |

## Verification
A wrong state or a wrong count in the sequencer shows up on the memory pins within the same transfer. A read wait that is too short makes the bench's memory model present garbage at the capture edge, so the response data is wrong on that beat. A write pulse that is too short is caught when write enable rises. A missing turnaround shows up as bus overlap on the first cycle after the direction change, and it also shortens the latency by two cycles. Lane or fill errors appear in the first byte-masked response or in the readback after it.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SETUP,
    ST_RD_WAIT,
    ST_RD_CAPTURE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER,
    ST_TURNAROUND
  } ctrl_state_t;

  typedef enum logic [1:0] {
    LAST_NONE,
    LAST_RD,
    LAST_WR
  } last_op_t;

  // whole clock cycles covering a limit, never below one
  function automatic int ps_to_cycles(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC  = 1,
  parameter int WP_CYC  = 2,
  parameter int REC_CYC = 1,
  parameter int TA_CYC  = 2,
  parameter int CNT_W   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        rsp_pending,
  output logic        req_ready,
  output logic        req_fire,
  output ctrl_state_t state_d,
  output logic        rd_done,
  output logic        wr_done
);

  ctrl_state_t      state_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             op_wr_q, op_wr_d;
  last_op_t         last_q, last_d;
  logic             need_ta;

  assign req_ready = (state_q == ST_IDLE) && !rsp_pending;
  assign req_fire  = req_valid && req_ready;
  assign need_ta   = ((last_q == LAST_RD) && req_write) ||
                     ((last_q == LAST_WR) && !req_write);
  assign rd_done   = (state_q == ST_RD_CAPTURE);
  assign wr_done   = (state_q == ST_WR_RECOVER) && (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    op_wr_d = op_wr_q;
    last_d  = last_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_fire) begin
          op_wr_d = req_write;
          if (need_ta) begin
            state_d = ST_TURNAROUND;
            cnt_d   = CNT_W'(TA_CYC - 1);
          end else begin
            state_d = req_write ? ST_WR_SETUP : ST_RD_SETUP;
          end
        end
      end
      ST_TURNAROUND: begin
        if (cnt_q == '0) state_d = op_wr_q ? ST_WR_SETUP : ST_RD_SETUP;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_RD_SETUP: begin
        state_d = ST_RD_WAIT;
        cnt_d   = CNT_W'(RD_CYC - 1);
      end
      ST_RD_WAIT: begin
        if (cnt_q == '0) state_d = ST_RD_CAPTURE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_RD_CAPTURE: begin
        state_d = ST_IDLE;
        last_d  = LAST_RD;
      end
      ST_WR_SETUP: begin
        state_d = ST_WR_PULSE;
        cnt_d   = CNT_W'(WP_CYC - 1);
      end
      ST_WR_PULSE: begin
        if (cnt_q == '0) begin
          state_d = ST_WR_RECOVER;
          cnt_d   = CNT_W'(REC_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WR_RECOVER: begin
        if (cnt_q == '0) begin
          state_d = ST_IDLE;
          last_d  = LAST_WR;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      op_wr_q <= 1'b0;
      last_q  <= LAST_NONE;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      op_wr_q <= op_wr_d;
      last_q  <= last_d;
    end
  end

endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANES  = 2,
  parameter int TA_CYC = 2,
  parameter int WP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_state_t       state_d,
  input  logic              req_fire,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [LANES-1:0]  lane_sel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] mem_dq_out
);

  localparam int LANE_W = DATA_W / LANES;
  localparam int QW     = $clog2(TA_CYC + 1) + 1;
  localparam int PW     = $clog2(WP_CYC + 1) + 1;

  logic [LANES-1:0]  be_q, be_sel, be_n_d;
  logic [DATA_W-1:0] wd_q, wd_sel, dq_d;
  logic              sel_d, rd_d, wp_d, wrst_d;

  assign be_sel = req_fire ? req_be    : be_q;
  assign wd_sel = req_fire ? req_wdata : wd_q;
  assign lane_sel = be_q;

  always_comb begin
    sel_d  = state_d inside {ST_RD_SETUP, ST_RD_WAIT, ST_RD_CAPTURE,
                             ST_WR_SETUP, ST_WR_PULSE, ST_WR_RECOVER};
    rd_d   = state_d inside {ST_RD_WAIT, ST_RD_CAPTURE};
    wp_d   = (state_d == ST_WR_PULSE);
    wrst_d = state_d inside {ST_WR_SETUP, ST_WR_PULSE, ST_WR_RECOVER};
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign be_n_d[l] = ~(sel_d & be_sel[l]);
    assign dq_d[l*LANE_W +: LANE_W] =
      (wrst_d && be_sel[l]) ? wd_sel[l*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      be_q       <= '0;
      wd_q       <= '0;
      mem_addr   <= '0;
      mem_cs_n   <= 1'b1;
      mem_rd_n   <= 1'b1;
      mem_wr_n   <= 1'b1;
      mem_be_n   <= '1;
      mem_dq_oe  <= 1'b0;
      mem_dq_out <= '0;
    end else begin
      if (req_fire) begin
        be_q     <= req_be;
        wd_q     <= req_wdata;
        mem_addr <= req_addr;
      end
      mem_cs_n   <= ~sel_d;
      mem_rd_n   <= ~rd_d;
      mem_wr_n   <= ~wp_d;
      mem_be_n   <= be_n_d;
      mem_dq_oe  <= wrst_d;
      mem_dq_out <= dq_d;
    end
  end

  // window counters for the checks below
  logic [QW-1:0] quiet_cnt, rdhi_cnt;
  logic [PW-1:0] wlo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_cnt <= QW'(TA_CYC);
      rdhi_cnt  <= QW'(TA_CYC);
      wlo_cnt   <= '0;
    end else begin
      quiet_cnt <= mem_dq_oe ? '0 :
                   ((quiet_cnt == QW'(TA_CYC)) ? quiet_cnt : quiet_cnt + 1'b1);
      rdhi_cnt  <= !mem_rd_n ? '0 :
                   ((rdhi_cnt == QW'(TA_CYC)) ? rdhi_cnt : rdhi_cnt + 1'b1);
      wlo_cnt   <= mem_wr_n ? '0 :
                   ((wlo_cnt == PW'(WP_CYC)) ? wlo_cnt : wlo_cnt + 1'b1);
    end
  end

  p_oe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_rd_n);

  p_we_guard_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> (!mem_cs_n && mem_rd_n));

  p_standby_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_rd_n && mem_wr_n && (&mem_be_n)));

  p_gap_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rd_n) |-> (quiet_cnt >= QW'(TA_CYC)));

  p_gap_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (rdhi_cnt >= QW'(TA_CYC)));

  p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_n) |-> (wlo_cnt >= PW'(WP_CYC)));

endmodule

// File: rtl/sram_ctrl_rsp.sv
module sram_ctrl_rsp #(
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_done,
  input  logic              wr_done,
  input  logic [LANES-1:0]  lane_sel,
  input  logic [DATA_W-1:0] mem_dq_in,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] cap_d;

  for (genvar l = 0; l < LANES; l++) begin : g_fill
    assign cap_d[l*LANE_W +: LANE_W] =
      lane_sel[l] ? mem_dq_in[l*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_done) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= cap_d;
    end else if (wr_done) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= '0;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_rsp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_no_done_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !(rd_done || wr_done));

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int LANES     = 2,
  parameter int CLK_PS    = 5000,
  parameter int T_AA_PS   = 15000,
  parameter int T_OE_PS   = 7000,
  parameter int T_WC_PS   = 15000,
  parameter int T_WP_PS   = 10000,
  parameter int T_AW_PS   = 10000,
  parameter int T_DS_PS   = 7000,
  parameter int T_REL_PS  = 7000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in
);

  // address is held for setup + wait + capture; read enable for wait + capture
  localparam int RD_CYC  = imax(1, imax(ps_to_cycles(T_AA_PS, CLK_PS) - 2,
                                        ps_to_cycles(T_OE_PS, CLK_PS) - 1));
  // data and address are already valid one setup cycle before the pulse
  localparam int WP_CYC  = imax(ps_to_cycles(T_WP_PS, CLK_PS),
                                imax(ps_to_cycles(T_DS_PS, CLK_PS) - 1,
                                     ps_to_cycles(T_AW_PS, CLK_PS) - 1));
  localparam int REC_CYC = imax(1, ps_to_cycles(T_WC_PS, CLK_PS) - 1 - WP_CYC);
  localparam int TA_CYC  = ps_to_cycles(T_REL_PS, CLK_PS);
  localparam int MAX_CYC = imax(imax(RD_CYC, WP_CYC), imax(REC_CYC, TA_CYC));
  localparam int CNT_W   = imax(1, $clog2(MAX_CYC + 1));

  ctrl_state_t      state_d;
  logic             req_fire, rd_done, wr_done;
  logic [LANES-1:0] lane_sel;

  sram_ctrl_fsm #(
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .REC_CYC(REC_CYC),
    .TA_CYC (TA_CYC),
    .CNT_W  (CNT_W)
  ) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .rsp_pending(rsp_valid),
    .req_ready  (req_ready),
    .req_fire   (req_fire),
    .state_d    (state_d),
    .rd_done    (rd_done),
    .wr_done    (wr_done)
  );

  sram_ctrl_pins #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES),
    .TA_CYC(TA_CYC),
    .WP_CYC(WP_CYC)
  ) i_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_d   (state_d),
    .req_fire  (req_fire),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .req_wdata (req_wdata),
    .lane_sel  (lane_sel),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_rd_n  (mem_rd_n),
    .mem_wr_n  (mem_wr_n),
    .mem_be_n  (mem_be_n),
    .mem_dq_oe (mem_dq_oe),
    .mem_dq_out(mem_dq_out)
  );

  sram_ctrl_rsp #(
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) i_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_done  (rd_done),
    .wr_done  (wr_done),
    .lane_sel (lane_sel),
    .mem_dq_in(mem_dq_in),
    .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

endmodule

// File: tb/test_sram_ctrl.sv
`timescale 1ns/1ps
module test_sram_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        rsp_valid, rsp_ready = 1'b0;
  logic [15:0] rsp_rdata;
  logic [15:0] mem_addr, mem_dq_out;
  logic [15:0] mem_dq_in = '0;
  logic        mem_cs_n, mem_rd_n, mem_wr_n, mem_dq_oe;
  logic [1:0]  mem_be_n;

  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  sram_ctrl i_sram_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n),
    .mem_wr_n(mem_wr_n), .mem_be_n(mem_be_n), .mem_dq_oe(mem_dq_oe),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural memory with timing checks ----------------
  logic [15:0] smem [int];
  logic [15:0] refm [int];
  int   addr_cnt, oe_cnt, we_cnt, dat_cnt, quiet, rdhi;
  logic p_wr_n, p_rd_n, p_cs_n, p_dq_oe;
  logic [15:0] p_addr, p_dq;
  logic [1:0]  p_be_n;

  function automatic logic [15:0] sget(input int a);
    return smem.exists(a) ? smem[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] rget(input int a);
    return refm.exists(a) ? refm[a] : 16'h0000;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      addr_cnt = 0; oe_cnt = 0; we_cnt = 0; dat_cnt = 0;
      quiet = 100; rdhi = 100;
      p_wr_n = 1'b1; p_rd_n = 1'b1; p_cs_n = 1'b1; p_dq_oe = 1'b0;
      p_addr = '0; p_dq = '0; p_be_n = 2'b11;
    end else begin
      // end of a write: old counts cover the cycles before the rise
      if (!p_wr_n && mem_wr_n) begin
        check(we_cnt >= 2, "R4", "write pulse cycles", we_cnt, 2);
        check(addr_cnt >= 2, "R4", "address held before write end", addr_cnt, 2);
        check(dat_cnt >= 2, "R4", "data held before write end", dat_cnt, 2);
        for (int l = 0; l < 2; l++) begin
          if (!p_be_n[l]) begin
            logic [15:0] w;
            w = sget(int'(p_addr));
            w[l*8 +: 8] = p_dq[l*8 +: 8];
            smem[int'(p_addr)] = w;
          end else begin
            check(p_dq[l*8 +: 8] == 8'h00, "R7", "unselected lane data",
                  int'(p_dq[l*8 +: 8]), 0);
          end
        end
      end
      check(!(mem_dq_oe && !mem_rd_n), "R8", "bus overlap",
            {mem_dq_oe, mem_rd_n}, 1);
      check(!mem_cs_n || (mem_rd_n && mem_wr_n && mem_be_n == 2'b11), "R10",
            "controls while deselected", {mem_rd_n, mem_wr_n, mem_be_n}, 4'hF);
      check(mem_wr_n || (!mem_cs_n && mem_rd_n), "R12", "write enable guard",
            {mem_cs_n, mem_rd_n}, 1);
      if (!mem_rd_n && p_rd_n)
        check(quiet >= 2, "R9", "quiet cycles before read enable", quiet, 2);
      if (mem_dq_oe && !p_dq_oe)
        check(rdhi >= 2, "R9", "read enable high before drive", rdhi, 2);
      // update windows including the current cycle
      addr_cnt = !mem_cs_n ? ((!p_cs_n && mem_addr == p_addr) ? addr_cnt + 1 : 1) : 0;
      oe_cnt   = (!mem_cs_n && !mem_rd_n && mem_wr_n) ? oe_cnt + 1 : 0;
      we_cnt   = !mem_wr_n ? we_cnt + 1 : 0;
      dat_cnt  = mem_dq_oe ? ((p_dq_oe && mem_dq_out == p_dq) ? dat_cnt + 1 : 1) : 0;
      quiet    = mem_dq_oe ? 0 : (quiet < 100 ? quiet + 1 : quiet);
      rdhi     = !mem_rd_n ? 0 : (rdhi < 100 ? rdhi + 1 : rdhi);
      for (int l = 0; l < 2; l++) begin
        logic [15:0] sw;
        sw = sget(int'(mem_addr));
        mem_dq_in[l*8 +: 8] = (!mem_be_n[l] && addr_cnt >= 3 && oe_cnt >= 2) ?
                              sw[l*8 +: 8] : (8'hA5 ^ mem_addr[7:0] ^ 8'(l * 8'h3C));
      end
      p_wr_n = mem_wr_n; p_rd_n = mem_rd_n; p_cs_n = mem_cs_n;
      p_dq_oe = mem_dq_oe; p_addr = mem_addr; p_dq = mem_dq_out; p_be_n = mem_be_n;
    end
  end

  // ---------------- request driver and scoreboard ----------------
  int last_dir = 0;  // 0 none, 1 read, 2 write

  task automatic xfer(input bit wr, input logic [15:0] a, input logic [1:0] be,
                      input logic [15:0] wd, input int hold, input string tag);
    int lat, exp_lat;
    bit need_ta;
    logic [15:0] exp_d, held, cur;
    need_ta = (last_dir == 1 && wr) || (last_dir == 2 && !wr);
    exp_lat = (wr ? 4 : 3) + (need_ta ? 2 : 0);
    cur = rget(int'(a));
    exp_d = '0;
    for (int l = 0; l < 2; l++) begin
      if (be[l]) begin
        if (wr) cur[l*8 +: 8] = wd[l*8 +: 8];
        else    exp_d[l*8 +: 8] = cur[l*8 +: 8];
      end
    end
    if (wr) refm[int'(a)] = cur;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 40) begin
      check(!req_ready, "R2", "ready while busy", req_ready, 0);
      lat++;
      @(negedge clk);
    end
    check(lat == exp_lat, need_ta ? "R9" : (wr ? "R4" : "R3"),
          "response latency", lat, exp_lat);
    check(rsp_rdata == exp_d, tag, "response data", rsp_rdata, exp_d);
    held = rsp_rdata;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(rsp_valid && rsp_rdata == held && !req_ready, "R2",
            "response held", {rsp_valid, req_ready}, 2);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(!rsp_valid && req_ready, "R2", "response consumed",
          {rsp_valid, req_ready}, 1);
    last_dir = wr ? 2 : 1;
  endtask

  initial begin
    #(5.0 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_cs_n && mem_rd_n && mem_wr_n && mem_be_n == 2'b11 && !mem_dq_oe,
          "R1", "pins after reset", {mem_cs_n, mem_rd_n, mem_wr_n, mem_be_n, mem_dq_oe}, 8'h3E);
    check(req_ready && !rsp_valid, "R1", "handshake after reset",
          {req_ready, rsp_valid}, 2);

    xfer(1, 16'h0010, 2'b11, 16'h1234, 0, "R2");   // first write, no gap
    xfer(0, 16'h0010, 2'b11, 16'h0000, 0, "R3");   // read after write
    xfer(0, 16'h0010, 2'b11, 16'h0000, 0, "R3");   // read after read
    xfer(1, 16'h0010, 2'b01, 16'hAA55, 0, "R5");   // lower lane only
    xfer(1, 16'h0010, 2'b10, 16'h77CC, 0, "R5");   // upper lane only
    xfer(0, 16'h0010, 2'b11, 16'h0000, 0, "R7");   // 0x7755
    xfer(0, 16'h0010, 2'b01, 16'h0000, 0, "R6");   // 0x0055
    xfer(0, 16'h0010, 2'b10, 16'h0000, 0, "R6");   // 0x7700
    xfer(1, 16'h0010, 2'b00, 16'hFFFF, 0, "R11");  // empty mask write
    xfer(0, 16'h0010, 2'b00, 16'h0000, 0, "R11");  // empty mask read -> 0
    xfer(0, 16'h0010, 2'b11, 16'h0000, 0, "R11");  // unchanged 0x7755
    xfer(0, 16'h0010, 2'b11, 16'h0000, 3, "R2");   // back-pressure
    xfer(1, 16'h0000, 2'b11, 16'hC0DE, 2, "R2");
    xfer(1, 16'hFFFF, 2'b11, 16'hBEEF, 0, "R4");
    xfer(0, 16'hFFFF, 2'b11, 16'h0000, 0, "R3");
    xfer(0, 16'h0000, 2'b11, 16'h0000, 0, "R3");

    lf = 32'h1ACE_B00C;
    for (int i = 0; i < 200; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      xfer(lf[0], {12'hF0F, lf[4:1]}, lf[6:5], lf[22:7], (lf[24:23] == 2'b11) ? 2 : 0,
           lf[0] ? "R7" : "R6");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule